// File: doc/BRIEF.md
# Queue Doorbell Decoder with Interrupt Request

This block sits behind the register window of a storage controller and turns 32-bit host writes in the doorbell area into pointer updates for its queue pairs. The area begins at byte offset 0x1000. Each queue pair takes 8 bytes: the submission-queue tail doorbell comes first and the completion-queue head doorbell follows 4 bytes later. For every queue the block holds an existence flag, a size and the current pointer. The fetch engine reads all submission tails, and the posting engine reads all completion heads, through flat vector outputs.

Queues are created and deleted through a side configuration port. The posting engine advances a completion queue's internal tail with a one-cycle post strobe. A write that is misaligned, below the area, aimed at a queue that does not exist, or carrying a pointer value of at least the queue size is dropped, and a drop pulse marks it. A valid completion-head write that still leaves entries pending produces exactly one interrupt request. That request is a message vector if message interrupts are on, a pin pulse if they are off, or a masked-interrupt marker if the queue has interrupts disabled. Queue 0 is the admin pair.

Top module: `qdb_ctrl`

## Requirements
- R1: A write to offset 0x1000 + 8*q (bits [2:0] of the offset = 000) for an existing submission queue q, with a value below its size, raises `sq_upd_o` for one cycle in the cycle after the write, with `upd_qid_o` = q. At most one of `sq_upd_o`, `cq_upd_o` and `drop_o` is high in any cycle, and all three are low after an idle cycle.
- R2: A write to offset 0x1000 + 8*q + 4 for an existing completion queue q, with a value below its size, raises `cq_upd_o` for one cycle in the cycle after the write, with `upd_qid_o` = q. The new head appears in slice q of `cq_head_o`.
- R3: A write whose address has bits [1:0] not equal to 00 is dropped. `drop_o` pulses and no pointer changes.
- R4: A write below 0x1000, a write to a queue index of NUM_Q or more, and a write to a queue whose flag is clear are each dropped, with a `drop_o` pulse.
- R5: Only data bits [15:0] form the pointer, and bits [31:16] are ignored. A value equal to or above the queue size is dropped and leaves the stored pointer unchanged.
- R6: On an accepted completion-head write whose value differs from that queue's internal tail, with interrupts enabled for the queue and `msix_en_i` high, `irq_msix_o` pulses and `irq_vec_o` carries the queue's vector. `irq_vec_o` is 0 in every other cycle.
- R7: In the same case with `msix_en_i` low, `irq_pin_o` pulses instead.
- R8: In the same case with interrupts disabled for the queue, only `irq_masked_o` pulses.
- R9: An accepted completion-head write equal to the internal tail, or any other kind of write, produces no interrupt output.
- R10: A create command sets the queue's flag, sets its size and vector/enable fields, and clears its pointers to 0. A delete command clears the flag, and later writes to that queue are dropped.
- R11: A post strobe advances an existing completion queue's internal tail by one, wrapping to 0 when it would reach the size.
- R12: After reset, all outputs are 0 and no queue exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host write strobe |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | 32 | Write data |
| cfg_valid_i | input | 1 | Configuration command strobe |
| cfg_cq_i | input | 1 | 1 selects the completion queue, 0 the submission queue |
| cfg_create_i | input | 1 | 1 creates, 0 deletes |
| cfg_qid_i | input | QID_W | Target queue index |
| cfg_size_i | input | 16 | Queue size in entries |
| cfg_ien_i | input | 1 | Interrupt enable (completion queues) |
| cfg_vec_i | input | VEC_W | Message vector (completion queues) |
| post_valid_i | input | 1 | Advance a completion queue's internal tail |
| post_qid_i | input | QID_W | Queue to advance |
| msix_en_i | input | 1 | Message interrupts enabled |
| sq_upd_o | output | 1 | Submission tail accepted |
| cq_upd_o | output | 1 | Completion head accepted |
| upd_qid_o | output | QID_W | Queue index of the accepted write |
| drop_o | output | 1 | Write dropped |
| sq_tail_o | output | NUM_Q*16 | All submission tails, queue q at [16q+15:16q] |
| cq_head_o | output | NUM_Q*16 | All completion heads, queue q at [16q+15:16q] |
| irq_msix_o | output | 1 | Message vector request |
| irq_vec_o | output | VEC_W | Vector of the request |
| irq_pin_o | output | 1 | Pin pulse |
| irq_masked_o | output | 1 | Interrupt was due but masked |

## Verification
The assertions take it for granted that the configuration port never targets a queue in the same cycle as a doorbell write or post to that same queue. They also assume `msix_en_i` is driven to a known level in every cycle after reset. The stimulus keeps configuration commands in cycles of their own and holds `msix_en_i` steady across each write it observes. Within those rules, the bench mixes aligned, misaligned, below-area and out-of-range addresses, boundary pointer values and wrap-around posts.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam int PTR_W = 16;
  typedef logic [PTR_W-1:0] ptr_t;
endpackage

// File: rtl/qdb_addr_dec.sv
module qdb_addr_dec #(
  parameter int ADDR_W  = 16,
  parameter int DB_BASE = 'h1000,
  parameter int NUM_Q   = 4,
  parameter int QID_W   = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ok_o,
  output logic              is_cq_o,
  output logic [QID_W-1:0]  qid_o
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-4:0] idx;

  always_comb begin
    off     = addr_i - ADDR_W'(DB_BASE);
    idx     = off[ADDR_W-1:3];
    is_cq_o = off[2];
    qid_o   = idx[QID_W-1:0];
    ok_o    = (addr_i >= ADDR_W'(DB_BASE)) && (off[1:0] == 2'b00)
              && (idx < (ADDR_W-3)'(NUM_Q));
  end
endmodule

// File: rtl/qdb_qstate.sv
module qdb_qstate import qdb_pkg::*; #(
  parameter int NUM_Q = 4,
  parameter int QID_W = 2,
  parameter int VEC_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sq_wr_i,
  input  logic                        cq_wr_i,
  input  logic [QID_W-1:0]            wr_qid_i,
  input  ptr_t                        wr_val_i,
  input  logic                        post_i,
  input  logic [QID_W-1:0]            post_qid_i,
  input  logic                        cfg_valid_i,
  input  logic                        cfg_cq_i,
  input  logic                        cfg_create_i,
  input  logic [QID_W-1:0]            cfg_qid_i,
  input  ptr_t                        cfg_size_i,
  input  logic                        cfg_ien_i,
  input  logic [VEC_W-1:0]            cfg_vec_i,
  output logic [NUM_Q-1:0]            sq_ex_o,
  output logic [NUM_Q-1:0]            cq_ex_o,
  output logic [NUM_Q-1:0][PTR_W-1:0] sq_size_o,
  output logic [NUM_Q-1:0][PTR_W-1:0] sq_tail_o,
  output logic [NUM_Q-1:0][PTR_W-1:0] cq_size_o,
  output logic [NUM_Q-1:0][PTR_W-1:0] cq_head_o,
  output logic [NUM_Q-1:0][PTR_W-1:0] cq_tail_o,
  output logic [NUM_Q-1:0]            cq_ien_o,
  output logic [NUM_Q-1:0][VEC_W-1:0] cq_vec_o
);
  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    logic cfg_hit, wr_hit, post_hit;
    logic [PTR_W:0] tail_inc;
    assign cfg_hit  = cfg_valid_i && (cfg_qid_i == QID_W'(i));
    assign wr_hit   = wr_qid_i == QID_W'(i);
    assign post_hit = post_i && (post_qid_i == QID_W'(i)) && cq_ex_o[i];
    assign tail_inc = {1'b0, cq_tail_o[i]} + 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sq_ex_o[i]   <= 1'b0;
        sq_size_o[i] <= '0;
        sq_tail_o[i] <= '0;
      end else if (cfg_hit && !cfg_cq_i) begin
        sq_ex_o[i] <= cfg_create_i;
        if (cfg_create_i) begin
          sq_size_o[i] <= cfg_size_i;
          sq_tail_o[i] <= '0;
        end
      end else if (sq_wr_i && wr_hit) begin
        sq_tail_o[i] <= wr_val_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cq_ex_o[i]   <= 1'b0;
        cq_size_o[i] <= '0;
        cq_head_o[i] <= '0;
        cq_tail_o[i] <= '0;
        cq_ien_o[i]  <= 1'b0;
        cq_vec_o[i]  <= '0;
      end else if (cfg_hit && cfg_cq_i) begin
        cq_ex_o[i] <= cfg_create_i;
        if (cfg_create_i) begin
          cq_size_o[i] <= cfg_size_i;
          cq_head_o[i] <= '0;
          cq_tail_o[i] <= '0;
          cq_ien_o[i]  <= cfg_ien_i;
          cq_vec_o[i]  <= cfg_vec_i;
        end
      end else begin
        if (cq_wr_i && wr_hit) cq_head_o[i] <= wr_val_i;
        if (post_hit)
          cq_tail_o[i] <= (tail_inc >= {1'b0, cq_size_o[i]}) ? '0 : tail_inc[PTR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/qdb_irq.sv
module qdb_irq #(
  parameter int VEC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             ien_i,
  input  logic             msix_en_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             msix_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             pin_o,
  output logic             masked_o
);
  logic go_msix, go_pin, go_mask;
  assign go_msix = fire_i && ien_i && msix_en_i;
  assign go_pin  = fire_i && ien_i && !msix_en_i;
  assign go_mask = fire_i && !ien_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msix_o   <= 1'b0;
      vec_o    <= '0;
      pin_o    <= 1'b0;
      masked_o <= 1'b0;
    end else begin
      msix_o   <= go_msix;
      vec_o    <= go_msix ? vec_i : '0;
      pin_o    <= go_pin;
      masked_o <= go_mask;
    end
  end
endmodule

// File: rtl/qdb_ctrl.sv
module qdb_ctrl import qdb_pkg::*; #(
  parameter int NUM_Q   = 4,
  parameter int ADDR_W  = 16,
  parameter int VEC_W   = 3,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_valid_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [31:0]            wr_data_i,
  input  logic                   cfg_valid_i,
  input  logic                   cfg_cq_i,
  input  logic                   cfg_create_i,
  input  logic [QID_W-1:0]       cfg_qid_i,
  input  logic [15:0]            cfg_size_i,
  input  logic                   cfg_ien_i,
  input  logic [VEC_W-1:0]       cfg_vec_i,
  input  logic                   post_valid_i,
  input  logic [QID_W-1:0]       post_qid_i,
  input  logic                   msix_en_i,
  output logic                   sq_upd_o,
  output logic                   cq_upd_o,
  output logic [QID_W-1:0]       upd_qid_o,
  output logic                   drop_o,
  output logic [NUM_Q*16-1:0]    sq_tail_o,
  output logic [NUM_Q*16-1:0]    cq_head_o,
  output logic                   irq_msix_o,
  output logic [VEC_W-1:0]       irq_vec_o,
  output logic                   irq_pin_o,
  output logic                   irq_masked_o
);
  logic             ok, is_cq;
  logic [QID_W-1:0] qid;
  logic [NUM_Q-1:0] sq_ex, cq_ex, cq_ien;
  logic [NUM_Q-1:0][PTR_W-1:0] sq_size, sq_tail, cq_size, cq_head, cq_tail;
  logic [NUM_Q-1:0][VEC_W-1:0] cq_vec;
  ptr_t new_val, sel_size;
  logic sel_ex, accept, sq_wr, cq_wr, fire;
  logic unused_hi;

  assign unused_hi = ^wr_data_i[31:PTR_W];
  assign new_val   = wr_data_i[PTR_W-1:0];

  qdb_addr_dec #(
    .ADDR_W(ADDR_W), .DB_BASE(DB_BASE), .NUM_Q(NUM_Q), .QID_W(QID_W)
  ) u_dec (
    .addr_i(wr_addr_i), .ok_o(ok), .is_cq_o(is_cq), .qid_o(qid)
  );

  assign sel_ex   = is_cq ? cq_ex[qid]   : sq_ex[qid];
  assign sel_size = is_cq ? cq_size[qid] : sq_size[qid];
  assign accept   = wr_valid_i && ok && sel_ex && (new_val < sel_size);
  assign sq_wr    = accept && !is_cq;
  assign cq_wr    = accept && is_cq;
  // pending entries remain only while head trails the internal tail
  assign fire     = cq_wr && (new_val != cq_tail[qid]);

  qdb_qstate #(.NUM_Q(NUM_Q), .QID_W(QID_W), .VEC_W(VEC_W)) u_state (
    .clk_i, .rst_ni,
    .sq_wr_i(sq_wr), .cq_wr_i(cq_wr), .wr_qid_i(qid), .wr_val_i(new_val),
    .post_i(post_valid_i), .post_qid_i(post_qid_i),
    .cfg_valid_i, .cfg_cq_i, .cfg_create_i, .cfg_qid_i, .cfg_size_i,
    .cfg_ien_i, .cfg_vec_i,
    .sq_ex_o(sq_ex), .cq_ex_o(cq_ex), .sq_size_o(sq_size), .sq_tail_o(sq_tail),
    .cq_size_o(cq_size), .cq_head_o(cq_head), .cq_tail_o(cq_tail),
    .cq_ien_o(cq_ien), .cq_vec_o(cq_vec)
  );

  qdb_irq #(.VEC_W(VEC_W)) u_irq (
    .clk_i, .rst_ni, .fire_i(fire), .ien_i(cq_ien[qid]), .msix_en_i,
    .vec_i(cq_vec[qid]), .msix_o(irq_msix_o), .vec_o(irq_vec_o),
    .pin_o(irq_pin_o), .masked_o(irq_masked_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_upd_o  <= 1'b0;
      cq_upd_o  <= 1'b0;
      drop_o    <= 1'b0;
      upd_qid_o <= '0;
    end else begin
      sq_upd_o  <= sq_wr;
      cq_upd_o  <= cq_wr;
      drop_o    <= wr_valid_i && !accept;
      upd_qid_o <= accept ? qid : '0;
    end
  end

  assign sq_tail_o = sq_tail;
  assign cq_head_o = cq_head;
endmodule

// File: rtl/qdb_chk.sv
module qdb_chk #(
  parameter int ADDR_W  = 16,
  parameter int DB_BASE = 'h1000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              msix_en_i,
  input logic              sq_upd_o,
  input logic              cq_upd_o,
  input logic              drop_o,
  input logic              irq_msix_o,
  input logic              irq_pin_o,
  input logic              irq_masked_o
);
  // R1
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sq_upd_o, cq_upd_o, drop_o}));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !sq_upd_o && !cq_upd_o && !drop_o);
  // R3
  misalign_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && (wr_addr_i[1:0] != 2'b00) |=> drop_o && !sq_upd_o && !cq_upd_o);
  // R4
  below_base_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && (wr_addr_i < ADDR_W'(DB_BASE)) |=> drop_o);
  // R6
  msix_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_msix_o |-> $past(msix_en_i));
  // R7
  pin_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pin_o |-> !$past(msix_en_i));
  // R8
  irq_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_msix_o, irq_pin_o, irq_masked_o}));
  // R9
  irq_needs_cq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_msix_o || irq_pin_o || irq_masked_o) |-> cq_upd_o);
endmodule

bind qdb_ctrl qdb_chk #(.ADDR_W(ADDR_W), .DB_BASE(DB_BASE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
  .msix_en_i(msix_en_i), .sq_upd_o(sq_upd_o), .cq_upd_o(cq_upd_o), .drop_o(drop_o),
  .irq_msix_o(irq_msix_o), .irq_pin_o(irq_pin_o), .irq_masked_o(irq_masked_o)
);

// File: tb/tb_qdb_ctrl.sv
module tb_qdb_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0; logic [15:0] wr_addr = 0; logic [31:0] wr_data = 0;
  logic cfg_valid = 0, cfg_cq = 0, cfg_create = 0; logic [1:0] cfg_qid = 0;
  logic [15:0] cfg_size = 0; logic cfg_ien = 0; logic [2:0] cfg_vec = 0;
  logic post_valid = 0; logic [1:0] post_qid = 0; logic msix_en = 0;
  logic sq_upd, cq_upd, drop, irq_msix, irq_pin, irq_masked;
  logic [1:0] upd_qid; logic [2:0] irq_vec;
  logic [NQ*16-1:0] sq_tail, cq_head;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdb_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cfg_valid_i(cfg_valid), .cfg_cq_i(cfg_cq),
    .cfg_create_i(cfg_create), .cfg_qid_i(cfg_qid), .cfg_size_i(cfg_size),
    .cfg_ien_i(cfg_ien), .cfg_vec_i(cfg_vec), .post_valid_i(post_valid),
    .post_qid_i(post_qid), .msix_en_i(msix_en), .sq_upd_o(sq_upd),
    .cq_upd_o(cq_upd), .upd_qid_o(upd_qid), .drop_o(drop), .sq_tail_o(sq_tail),
    .cq_head_o(cq_head), .irq_msix_o(irq_msix), .irq_vec_o(irq_vec),
    .irq_pin_o(irq_pin), .irq_masked_o(irq_masked)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, int got, int want);
    total++;
    if (got != want) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h at %0t", tag, got, want, $time);
    end
  endtask

  // behavioural reference model
  int m_sq_ex[NQ], m_sq_sz[NQ], m_sq_tl[NQ];
  int m_cq_ex[NQ], m_cq_sz[NQ], m_cq_hd[NQ], m_cq_tl[NQ], m_ien[NQ], m_vec[NQ];
  int e_sq_upd, e_cq_upd, e_qid, e_drop, e_msix, e_vec, e_pin, e_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        m_sq_ex[i] = 0; m_sq_sz[i] = 0; m_sq_tl[i] = 0; m_cq_ex[i] = 0;
        m_cq_sz[i] = 0; m_cq_hd[i] = 0; m_cq_tl[i] = 0; m_ien[i] = 0; m_vec[i] = 0;
      end
      {e_sq_upd, e_cq_upd, e_qid, e_drop, e_msix, e_vec, e_pin, e_mask} = '0;
    end else begin
      int a, off, q, v, isc, ok;
      e_sq_upd = 0; e_cq_upd = 0; e_qid = 0; e_drop = 0;
      e_msix = 0; e_vec = 0; e_pin = 0; e_mask = 0;
      if (wr_valid) begin
        a = int'(wr_addr); ok = 0;
        v = int'(wr_data & 32'hFFFF);
        if (a >= 'h1000 && a % 4 == 0) begin
          off = a - 'h1000; isc = (off >> 2) & 1; q = off >> 3;
          if (q < NQ) begin
            if (isc == 1) ok = (m_cq_ex[q] != 0 && v < m_cq_sz[q]) ? 1 : 0;
            else          ok = (m_sq_ex[q] != 0 && v < m_sq_sz[q]) ? 1 : 0;
          end
          if (ok == 1) begin
            e_qid = q;
            if (isc == 1) begin
              e_cq_upd = 1;
              if (v != m_cq_tl[q]) begin
                if (m_ien[q] != 0) begin
                  if (msix_en) begin e_msix = 1; e_vec = m_vec[q]; end
                  else e_pin = 1;
                end else e_mask = 1;
              end
              m_cq_hd[q] = v;
            end else begin
              e_sq_upd = 1; m_sq_tl[q] = v;
            end
          end
        end
        if (ok == 0) e_drop = 1;
      end
      if (post_valid && m_cq_ex[post_qid] != 0)
        m_cq_tl[post_qid] = (m_cq_tl[post_qid] + 1 >= m_cq_sz[post_qid]) ? 0 : m_cq_tl[post_qid] + 1;
      if (cfg_valid) begin
        if (cfg_cq) begin
          m_cq_ex[cfg_qid] = cfg_create;
          if (cfg_create) begin
            m_cq_sz[cfg_qid] = cfg_size; m_cq_hd[cfg_qid] = 0; m_cq_tl[cfg_qid] = 0;
            m_ien[cfg_qid] = cfg_ien; m_vec[cfg_qid] = cfg_vec;
          end
        end else begin
          m_sq_ex[cfg_qid] = cfg_create;
          if (cfg_create) begin m_sq_sz[cfg_qid] = cfg_size; m_sq_tl[cfg_qid] = 0; end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 sq_upd", sq_upd, e_sq_upd);
      chk("R2 cq_upd", cq_upd, e_cq_upd);
      chk("R1 upd_qid", upd_qid, e_qid);
      chk("R5 drop", drop, e_drop);
      chk("R6 irq_msix", irq_msix, e_msix);
      chk("R6 irq_vec", irq_vec, e_vec);
      chk("R7 irq_pin", irq_pin, e_pin);
      chk("R8 irq_masked", irq_masked, e_mask);
      for (int i = 0; i < NQ; i++) begin
        chk("R10 sq_tail", sq_tail[i*16 +: 16], m_sq_tl[i]);
        chk("R2 cq_head", cq_head[i*16 +: 16], m_cq_hd[i]);
      end
    end
  end

  task automatic db_wr(input int addr, input logic [31:0] data);
    @(negedge clk); wr_valid = 1; wr_addr = 16'(addr); wr_data = data;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic cfg(input bit cq, input bit create, input int q, input int sz,
                     input bit ien, input int vec);
    @(negedge clk);
    cfg_valid = 1; cfg_cq = cq; cfg_create = create; cfg_qid = 2'(q);
    cfg_size = 16'(sz); cfg_ien = ien; cfg_vec = 3'(vec);
    @(negedge clk); cfg_valid = 0;
  endtask

  task automatic post(input int q);
    @(negedge clk); post_valid = 1; post_qid = 2'(q);
    @(negedge clk); post_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD*3);
    // R12: reset state
    chk("R12 reset sq_upd", sq_upd, 0); chk("R12 reset drop", drop, 0);
    chk("R12 reset irq", {irq_msix, irq_pin, irq_masked}, 0);
    chk("R12 reset tails", int'(sq_tail[31:0]), 0);
    @(negedge clk); rst_n = 1;

    db_wr('h1000, 1);           chk("R4 no queue yet", drop, 1);
    cfg(0, 1, 0, 8, 0, 0);  cfg(1, 1, 0, 8, 1, 2);
    cfg(0, 1, 1, 4, 0, 0);  cfg(1, 1, 1, 4, 0, 0);
    cfg(1, 1, 2, 16, 1, 5);

    db_wr('h1000, 32'hABCD_0003); chk("R1 sq0 accepted", sq_upd, 1);
    chk("R5 high bits ignored", int'(sq_tail[15:0]), 3);
    db_wr('h1008, 2);           chk("R1 sq1 qid", upd_qid, 1);
    db_wr('h1004, 0);           chk("R9 equal tail no irq", irq_msix | irq_pin | irq_masked, 0);

    post(0); post(0); post(0);
    msix_en = 1;
    db_wr('h1004, 1);           chk("R6 msix", irq_msix, 1); chk("R6 vector", irq_vec, 2);
    msix_en = 0;
    db_wr('h1004, 2);           chk("R7 pin", irq_pin, 1);
    db_wr('h1004, 3);           chk("R9 caught up", irq_pin | irq_msix | irq_masked, 0);

    post(1);
    db_wr('h100C, 0);           chk("R8 masked", irq_masked, 1);

    db_wr('h1002, 5);           chk("R3 misaligned", drop, 1);
    db_wr('h1001, 5);           chk("R3 misaligned odd", drop, 1);
    chk("R3 tail kept", int'(sq_tail[15:0]), 3);
    db_wr('h1000, 8);           chk("R5 value at size", drop, 1);
    chk("R5 tail kept", int'(sq_tail[15:0]), 3);
    db_wr('h1000, 7);           chk("R5 max value", sq_upd, 1);
    db_wr('h1020, 0);           chk("R4 index beyond", drop, 1);
    db_wr('h1010, 0);           chk("R4 sq2 absent", drop, 1);
    db_wr('h0FFC, 0);           chk("R4 below area", drop, 1);
    db_wr('h1014, 0);           chk("R2 cq2 head", cq_upd, 1);

    // R11: wrap of internal tail on queue 1 (size 4), tail 1 -> 1 after four posts
    post(1); post(1); post(1); post(1);
    db_wr('h100C, 1);           chk("R11 wrap equal", irq_masked, 0);
    db_wr('h100C, 0);           chk("R11 wrap pending", irq_masked, 1);

    cfg(0, 0, 1, 0, 0, 0);
    db_wr('h1008, 1);           chk("R10 deleted", drop, 1);
    cfg(0, 1, 1, 4, 0, 0);      chk("R10 recreated ptr", int'(sq_tail[31:16]), 0);

    // back-to-back burst
    @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      wr_valid = 1; wr_addr = 16'('h1000 + (k % 8) * 4 + ((k == 5) ? 2 : 0));
      wr_data = 32'(k % 5);
      @(negedge clk);
    end
    wr_valid = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule